// File: doc/BRIEF.md
# Coalesced Write Sequencer

This block sits at the head node of a group of worker processors that share one time-division write channel into a common memory. A coalesce command supplies a start address, a chunk length S (data words per worker per turn) and a block count B. The sequencer then walks a fixed global schedule:

- blocks form the outer loop;
- workers form the middle loop;
- the word offset inside a chunk forms the inner loop.

In every slot it grants exactly one worker, takes that worker's word and issues one memory write. Each worker therefore holds non-contiguous pieces of the result, yet memory sees one gap-free ascending burst.

A granted worker reads a shared local-element index to know which of its stored words to present. A worker that is not ready stalls the whole schedule rather than being skipped, so the burst stays contiguous. The command stays busy until all B×P×S words are written, then signals completion with a single-cycle pulse. Memory is modelled as a write port that is always ready.

Top module: `coalesce_wr_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `busy`=0, `grant`=0, `mem_we`=0, `done`=0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Nonzero S and B make `busy`=1 and `cmd_ready`=0 from the next cycle.
- R3: While busy, `grant` has exactly one bit set; while idle it is all zeros. Bit j set means worker j owns the slot. Slots are visited in this order: block index outermost, worker index 0..P-1 in the middle, word offset 0..S-1 innermost.
- R4: The write for slot (block i, worker j, offset k) goes to address base + (i·P + j)·S + k. Each write therefore lands one address above the previous write.
- R5: `mem_wdata` equals the granted worker's `wk_data` lane in the same cycle. Lane j is bits [j·DATA_W +: DATA_W].
- R6: During slot (i, j, k), `elem_idx` equals i·S + k, the local index of the word the granted worker must present.
- R7: If the granted worker's `wk_valid` bit is low, `mem_we` stays 0 and the next cycle keeps the same grant and address. No slot is skipped.
- R8: Exactly B·P·S writes are issued. In the cycle after the final write, `done`=1 for one cycle and `busy`=0.
- R9: `cmd_valid` asserted while busy is ignored. The running schedule's addresses, grants and data continue unchanged.
- R10: A command with S=0 or B=0 issues no write. It raises `done` for one cycle in the next cycle and leaves the block idle.
- R11: Addresses wrap modulo 2^ADDR_W when the burst crosses the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Coalesce command offered |
| cmd_ready | output | 1 | High when idle and able to take a command |
| cmd_base | input | ADDR_W | First address of the burst |
| cmd_chunk | input | CHUNK_W | Words per worker per turn (S) |
| cmd_blocks | input | BLK_W | Number of blocks (B) |
| grant | output | NUM_WORKERS | One-hot slot owner |
| elem_idx | output | BLK_W+CHUNK_W | Local element index the granted worker presents |
| wk_data | input | NUM_WORKERS*DATA_W | Per-worker data lanes, flattened |
| wk_valid | input | NUM_WORKERS | Per-worker data valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | A schedule is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Grant, element index, write enable, address and data are all combinational from the slot registers and the current valid bits. They are therefore checked in the same cycle that the bench drives `wk_valid`: inputs change at the falling edge and outputs are sampled a moment later. The slot counters advance at the following rising edge. `done` and the return to idle come one cycle after the last write, or one cycle after taking a zero-length command. The bench samples them at the next falling edge and confirms the pulse has gone one cycle later. Stalls are checked in the stalled cycle (no write) and again in the following cycle (same grant and address).

// File: rtl/wcs_pkg.sv
package wcs_pkg;

   typedef enum logic {
      WCS_IDLE = 1'b0,
      WCS_RUN  = 1'b1
   } wcs_state_e;

   function automatic int unsigned wcs_idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wcs_slot_ctr.sv
module wcs_slot_ctr #(
   parameter int NUM_WORKERS = 4,
   parameter int WID_W       = 2,
   parameter int CHUNK_W     = 4,
   parameter int BLK_W       = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [CHUNK_W-1:0] chunk,
   input  logic [BLK_W-1:0]   blocks,
   output logic [WID_W-1:0]   wid,
   output logic [CHUNK_W-1:0] off,
   output logic [BLK_W-1:0]   blk,
   output logic               blk_end,
   output logic               last
);

   localparam logic [WID_W-1:0] WID_MAX = WID_W'(NUM_WORKERS - 1);

   logic [CHUNK_W-1:0] chunk_q;
   logic [BLK_W-1:0]   blocks_q;
   logic               off_end;
   logic               wid_end;

   assign off_end = (off == chunk_q - CHUNK_W'(1));
   assign wid_end = (wid == WID_MAX);
   assign blk_end = off_end && wid_end;
   assign last    = blk_end && (blk == blocks_q - BLK_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chunk_q  <= '0;
         blocks_q <= '0;
         wid      <= '0;
         off      <= '0;
         blk      <= '0;
      end else if (load) begin
         chunk_q  <= chunk;
         blocks_q <= blocks;
         wid      <= '0;
         off      <= '0;
         blk      <= '0;
      end else if (step) begin
         if (!off_end) begin
            off <= off + CHUNK_W'(1);
         end else begin
            off <= '0;
            if (!wid_end) begin
               wid <= wid + WID_W'(1);
            end else begin
               wid <= '0;
               blk <= blk + BLK_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/wcs_addr_gen.sv
module wcs_addr_gen #(
   parameter int ADDR_W  = 16,
   parameter int CHUNK_W = 4,
   parameter int IDX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               blk_end,
   input  logic [ADDR_W-1:0]  base,
   input  logic [CHUNK_W-1:0] chunk,
   input  logic [CHUNK_W-1:0] off,
   output logic [ADDR_W-1:0]  addr,
   output logic [IDX_W-1:0]   elem_idx
);

   logic [IDX_W-1:0]   elem_base;
   logic [CHUNK_W-1:0] stride_q;

   assign elem_idx = elem_base + IDX_W'(off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr      <= '0;
         elem_base <= '0;
         stride_q  <= '0;
      end else if (load) begin
         addr      <= base;
         elem_base <= '0;
         stride_q  <= chunk;
      end else if (step) begin
         addr <= addr + ADDR_W'(1);
         if (blk_end) begin
            elem_base <= elem_base + IDX_W'(stride_q);
         end
      end
   end

endmodule

// File: rtl/wcs_lane_mux.sv
module wcs_lane_mux #(
   parameter int NUM_WORKERS = 4,
   parameter int DATA_W      = 32,
   parameter int WID_W       = 2,
   parameter bit MUX_AND_OR  = 1'b1
) (
   input  logic                          active,
   input  logic [WID_W-1:0]              wid,
   input  logic [NUM_WORKERS*DATA_W-1:0] wk_data,
   input  logic [NUM_WORKERS-1:0]        wk_valid,
   output logic [NUM_WORKERS-1:0]        grant,
   output logic [DATA_W-1:0]             sel_data,
   output logic                          sel_valid
);

   for (genvar g = 0; g < NUM_WORKERS; g++) begin : g_grant
      assign grant[g] = active && (wid == WID_W'(g));
   end

   if (MUX_AND_OR) begin : g_andor
      always_comb begin
         sel_data  = '0;
         sel_valid = 1'b0;
         for (int g = 0; g < NUM_WORKERS; g++) begin
            if (grant[g]) begin
               sel_data  = sel_data | wk_data[g*DATA_W +: DATA_W];
               sel_valid = sel_valid | wk_valid[g];
            end
         end
      end
   end else begin : g_index
      assign sel_data  = wk_data[int'(wid)*DATA_W +: DATA_W];
      assign sel_valid = active && wk_valid[wid];
   end

endmodule

// File: rtl/coalesce_wr_seq.sv
module coalesce_wr_seq #(
   parameter int NUM_WORKERS = 4,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int CHUNK_W     = 4,
   parameter int BLK_W       = 4,
   parameter bit MUX_AND_OR  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_valid,
   output logic                          cmd_ready,
   input  logic [ADDR_W-1:0]             cmd_base,
   input  logic [CHUNK_W-1:0]            cmd_chunk,
   input  logic [BLK_W-1:0]              cmd_blocks,
   output logic [NUM_WORKERS-1:0]        grant,
   output logic [BLK_W+CHUNK_W-1:0]      elem_idx,
   input  logic [NUM_WORKERS*DATA_W-1:0] wk_data,
   input  logic [NUM_WORKERS-1:0]        wk_valid,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W-1:0]             mem_wdata,
   output logic                          busy,
   output logic                          done
);
   import wcs_pkg::*;

   localparam int WID_W = wcs_idx_bits(NUM_WORKERS);
   localparam int IDX_W = BLK_W + CHUNK_W;

   if (NUM_WORKERS < 2) begin : g_chk_workers
      $error("coalesce_wr_seq: NUM_WORKERS must be at least 2");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("coalesce_wr_seq: DATA_W must be at least 8");
   end
   if (CHUNK_W < 1 || BLK_W < 1 || ADDR_W < 2) begin : g_chk_fields
      $error("coalesce_wr_seq: field widths too small");
   end

   wcs_state_e         state_q;
   logic               accept;
   logic               zero_len;
   logic               load;
   logic               fire;
   logic               sel_valid;
   logic               blk_end;
   logic               last;
   logic [WID_W-1:0]   wid;
   logic [CHUNK_W-1:0] off;
   logic [BLK_W-1:0]   blk;

   assign busy      = (state_q == WCS_RUN);
   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;
   assign zero_len  = (cmd_chunk == '0) || (cmd_blocks == '0);
   assign load      = accept && !zero_len;
   assign fire      = busy && sel_valid;
   assign mem_we    = fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WCS_IDLE;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (zero_len) begin
               done <= 1'b1;
            end else begin
               state_q <= WCS_RUN;
            end
         end else if (fire && last) begin
            state_q <= WCS_IDLE;
            done    <= 1'b1;
         end
      end
   end

   wcs_slot_ctr #(
      .NUM_WORKERS(NUM_WORKERS),
      .WID_W      (WID_W),
      .CHUNK_W    (CHUNK_W),
      .BLK_W      (BLK_W)
   ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (fire),
      .chunk  (cmd_chunk),
      .blocks (cmd_blocks),
      .wid    (wid),
      .off    (off),
      .blk    (blk),
      .blk_end(blk_end),
      .last   (last)
   );

   wcs_addr_gen #(
      .ADDR_W (ADDR_W),
      .CHUNK_W(CHUNK_W),
      .IDX_W  (IDX_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (fire),
      .blk_end (blk_end),
      .base    (cmd_base),
      .chunk   (cmd_chunk),
      .off     (off),
      .addr    (mem_addr),
      .elem_idx(elem_idx)
   );

   wcs_lane_mux #(
      .NUM_WORKERS(NUM_WORKERS),
      .DATA_W     (DATA_W),
      .WID_W      (WID_W),
      .MUX_AND_OR (MUX_AND_OR)
   ) u_mux (
      .active   (busy),
      .wid      (wid),
      .wk_data  (wk_data),
      .wk_valid (wk_valid),
      .grant    (grant),
      .sel_data (mem_wdata),
      .sel_valid(sel_valid)
   );

   logic unused_blk;
   assign unused_blk = ^blk;

endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
   parameter int NUM_WORKERS = 4,
   parameter int ADDR_W      = 16,
   parameter int CHUNK_W     = 4,
   parameter int BLK_W       = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic                   cmd_ready,
   input logic [CHUNK_W-1:0]     cmd_chunk,
   input logic [BLK_W-1:0]       cmd_blocks,
   input logic [NUM_WORKERS-1:0] grant,
   input logic [NUM_WORKERS-1:0] wk_valid,
   input logic                   mem_we,
   input logic [ADDR_W-1:0]      mem_addr,
   input logic                   busy,
   input logic                   done
);

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(grant) == 1));

   assert_grant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (grant == '0));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (busy || done));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we) |=> (!busy || (mem_addr == $past(mem_addr) + ADDR_W'(1))));

   assert_write_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((grant & wk_valid) != '0));

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_we) |=> ($stable(grant) && $stable(mem_addr)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && ((cmd_chunk == '0) || (cmd_blocks == '0)))
      |=> (done && !busy));

endmodule

bind coalesce_wr_seq wcs_checker #(
   .NUM_WORKERS(NUM_WORKERS),
   .ADDR_W     (ADDR_W),
   .CHUNK_W    (CHUNK_W),
   .BLK_W      (BLK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_chunk (cmd_chunk),
   .cmd_blocks(cmd_blocks),
   .grant     (grant),
   .wk_valid  (wk_valid),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .busy      (busy),
   .done      (done)
);

// File: tb/coalesce_wr_seq_tb.sv
module coalesce_wr_seq_tb;

   localparam int P  = 4;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam int BW = 4;
   localparam int IW = BW + CW;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cmd_valid;
   logic            cmd_ready;
   logic [AW-1:0]   cmd_base;
   logic [CW-1:0]   cmd_chunk;
   logic [BW-1:0]   cmd_blocks;
   logic [P-1:0]    grant;
   logic [IW-1:0]   elem_idx;
   logic [P*DW-1:0] wk_data;
   logic [P-1:0]    wk_valid;
   logic            mem_we;
   logic [AW-1:0]   mem_addr;
   logic [DW-1:0]   mem_wdata;
   logic            busy;
   logic            done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   coalesce_wr_seq #(
      .NUM_WORKERS(P), .ADDR_W(AW), .DATA_W(DW), .CHUNK_W(CW), .BLK_W(BW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_base(cmd_base), .cmd_chunk(cmd_chunk), .cmd_blocks(cmd_blocks),
      .grant(grant), .elem_idx(elem_idx), .wk_data(wk_data), .wk_valid(wk_valid),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .done(done)
   );

   function automatic logic [DW-1:0] word_of(input int j, input int idx);
      return {8'(j) + 8'h50, 8'h3C, 16'(idx)};
   endfunction

   // each worker presents the word for the local index it is asked for
   always_comb begin
      for (int j = 0; j < P; j++) wk_data[j*DW +: DW] = word_of(j, int'(elem_idx));
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input int base, input int s, input int b,
                          input int stall_pct, input bit poke_busy);
      int ei = 0, ej = 0, ek = 0, nwr = 0, guard = 0;
      int total = s * b * P;
      logic [AW-1:0] eaddr = AW'(base);
      @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_base   = AW'(base);
      cmd_chunk  = CW'(s);
      cmd_blocks = BW'(b);
      #1 chk(cmd_ready == 1'b1, "R2 ready", cmd_ready, 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (total == 0) begin
         #1;
         chk(done == 1'b1 && busy == 1'b0 && mem_we == 1'b0, "R10 zero-length done", {done, busy, mem_we}, 3'b100);
         @(negedge clk);
         #1 chk(done == 1'b0, "R10 single pulse", done, 0);
         return;
      end
      while (nwr < total && guard < 4000) begin
         guard++;
         cmd_valid = poke_busy;
         if (poke_busy) begin
            cmd_base   = AW'($urandom);
            cmd_chunk  = CW'($urandom);
            cmd_blocks = BW'($urandom);
         end
         wk_valid = P'($urandom);
         wk_valid[ej] = (($urandom % 100) >= stall_pct);
         #1;
         chk(busy == 1'b1 && cmd_ready == 1'b0, "R2 busy", {busy, cmd_ready}, 2'b10);
         chk(grant == P'(1 << ej), "R3 slot order", grant, P'(1 << ej));
         if (wk_valid[ej]) begin
            chk(mem_we == 1'b1, "R7 write on valid", mem_we, 1);
            chk(mem_addr == eaddr, poke_busy ? "R9/R4/R11 address" : "R4/R11 address", mem_addr, eaddr);
            chk(mem_wdata == word_of(ej, ei * s + ek), "R5 data", mem_wdata, word_of(ej, ei * s + ek));
            chk(elem_idx == IW'(ei * s + ek), "R6 element index", elem_idx, ei * s + ek);
            eaddr = eaddr + AW'(1);
            nwr++;
            if (ek < s - 1) ek++;
            else begin
               ek = 0;
               if (ej < P - 1) ej++;
               else begin ej = 0; ei++; end
            end
         end else begin
            chk(mem_we == 1'b0, "R7 stall no write", mem_we, 0);
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      wk_valid  = '0;
      if (guard >= 4000) chk(1'b0, "R8 schedule hung", nwr, total);
      #1;
      chk(done == 1'b1 && busy == 1'b0 && cmd_ready == 1'b1, "R8 done after last write", {done, busy, cmd_ready}, 3'b101);
      @(negedge clk);
      #1 chk(done == 1'b0 && mem_we == 1'b0, "R8 single pulse", {done, mem_we}, 0);
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_C0A1));
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_base = '0; cmd_chunk = '0;
      cmd_blocks = '0; wk_valid = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cmd_ready == 1 && busy == 0 && grant == 0 && mem_we == 0 && done == 0,
          "R1 reset state", {cmd_ready, busy, grant, mem_we, done}, 8'h80);
      // directed corners
      run_cmd(16'h0100, 1, 1, 0, 1'b0);     // smallest burst
      run_cmd(16'h0200, 3, 2, 0, 1'b0);     // R3 R4 R6 ordering
      run_cmd(16'h0300, 2, 3, 60, 1'b0);    // R7 heavy stalls
      run_cmd(16'hFFFD, 2, 1, 0, 1'b0);     // R11 wrap
      run_cmd(16'h0400, 2, 2, 20, 1'b1);    // R9 commands during busy
      run_cmd(16'h0500, 0, 3, 0, 1'b0);     // R10 S=0
      run_cmd(16'h0600, 3, 0, 0, 1'b0);     // R10 B=0
      run_cmd(16'h0700, 15, 15, 10, 1'b0);  // largest fields
      // constrained random
      for (int n = 0; n < 25; n++) begin
         run_cmd(int'($urandom % 65536), 1 + int'($urandom % 6), 1 + int'($urandom % 5),
                 int'($urandom % 50), ($urandom % 4) == 0);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule